// File: doc/BRIEF.md
# Power Mode Controller

This block governs the low-power states of a small 8-bit microcontroller. A control register, loaded through a single-cycle write port, holds the mode request bits. Two states (CPU idle and software power-down) can only be reached by a protected pair of consecutive writes. The first write arms the state and the second write commits it. A third state, slow-down, is a plain register bit.

A pin held low forces power-down regardless of the register. The controller turns all of this into three synchronous enables. The first gates the CPU clock. The second gates the peripheral clock. The third keeps the oscillator running. In slow-down, both clock enables become a one-cycle pulse issued once every eight base clocks, so no clock is ever gated asynchronously.

The CPU, the peripherals, the oscillator itself and memory retention sit outside the block. They only see the enables it drives.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After a synchronous reset the control register reads 00h, `osc_run` is 1, and `cpu_ce` and `periph_ce` are both 1 every cycle.
- R2: A write with bit 0 set and bit 5 clear arms idle. If the very next write sets bit 5, the register shows bit 5 set, `cpu_ce` is 0 and `periph_ce` stays 1 from the cycle after that write.
- R3: A write with bit 5 set takes effect only when the immediately preceding write armed idle. Otherwise bit 5 reads back 0 and `cpu_ce` is unaffected. Any write that does not arm idle disarms a pending idle sequence.
- R4: While idle, a cycle with `periph_irq` high clears register bits 0 and 5 and raises `cpu_ce` on the next clock edge. Outside idle, `periph_irq` has no effect.
- R5: A write with bit 1 set and bit 6 clear, followed directly by a write with bit 6 set, enters software power-down. Bit 6 then reads 1, and `osc_run`, `cpu_ce` and `periph_ce` are 0. Only reset leaves this state, and interrupts do not.
- R6: One cycle after `hwpd_n` is sampled low, `osc_run`, `cpu_ce` and `periph_ce` are 0. One cycle after it is sampled high again, they return, with the register contents unchanged.
- R7: While bit 4 is set, `cpu_ce` and `periph_ce` are high in exactly one cycle of every 8. Clearing bit 4 by a write makes them high every cycle again.
- R8: Writes arriving while idle, software power-down or pin power-down is active leave the register unchanged.
- R9: Bits 7, 4, 3, 2, 1 and 0 of an accepted write are stored as written. Bits 5 and 6 are stored only when their sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| sfr_we | input | 1 | Control register write strobe |
| sfr_wdata | input | 8 | Control register write data |
| hwpd_n | input | 1 | Power-down pin, low forces power-down (already synchronised) |
| periph_irq | input | 1 | Interrupt request from an enabled peripheral |
| cpu_ce | output | 1 | CPU clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run request |
| ctl_q | output | 8 | Current control register value |

## Verification
The assertions assume that `hwpd_n` and `periph_irq` are already synchronous to `clk`. The slow-down pulse-spacing assertion assumes the register is not rewritten in the cycle that follows a pulse. The bench changes every input at the falling edge and holds it for whole cycles. It also leaves the write strobe low while it counts slow-down pulses, so the spacing claim is only exercised when no write intervenes.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int DIV_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sfr_we,
  input  logic [7:0] sfr_wdata,
  input  logic       hwpd_n,
  input  logic       periph_irq,
  output logic       cpu_ce,
  output logic       periph_ce,
  output logic       osc_run,
  output logic [7:0] ctl_q
);
  localparam int IDLE_ARM_B = 0;
  localparam int PD_ARM_B   = 1;
  localparam int SLOW_B     = 4;
  localparam int IDLE_GO_B  = 5;
  localparam int PD_GO_B    = 6;
  localparam logic [DIV_LOG2-1:0] DIV_LAST = '1;

  logic [7:0]          ctl_r;
  logic                arm_idle, arm_pd, hw_pd_q;
  logic [DIV_LOG2-1:0] div_cnt;

  wire idle_on = ctl_r[IDLE_GO_B];
  wire pd_sw   = ctl_r[PD_GO_B];
  wire slow_on = ctl_r[SLOW_B];
  wire halted  = idle_on | pd_sw | hw_pd_q;
  wire wr_ok   = sfr_we & ~halted;
  wire idle_go = wr_ok & arm_idle & sfr_wdata[IDLE_GO_B];
  wire pd_go   = wr_ok & arm_pd & sfr_wdata[PD_GO_B];
  wire wake    = idle_on & periph_irq & ~pd_sw & ~hw_pd_q;
  wire tick    = slow_on ? (div_cnt == DIV_LAST) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r    <= '0;
      arm_idle <= 1'b0;
      arm_pd   <= 1'b0;
      hw_pd_q  <= 1'b0;
      div_cnt  <= '0;
    end else begin
      hw_pd_q <= ~hwpd_n;
      if (osc_run) div_cnt <= div_cnt + 1'b1;
      if (wr_ok) begin
        ctl_r    <= {sfr_wdata[7], pd_go, idle_go, sfr_wdata[4:0]};
        arm_idle <= sfr_wdata[IDLE_ARM_B] & ~sfr_wdata[IDLE_GO_B];
        arm_pd   <= sfr_wdata[PD_ARM_B] & ~sfr_wdata[PD_GO_B];
      end else if (wake) begin
        ctl_r[IDLE_ARM_B] <= 1'b0;
        ctl_r[IDLE_GO_B]  <= 1'b0;
      end
    end
  end

  assign osc_run   = ~(pd_sw | hw_pd_q);
  assign periph_ce = osc_run & tick;
  assign cpu_ce    = periph_ce & ~idle_on;
  assign ctl_q     = ctl_r;

  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[IDLE_GO_B] |-> !cpu_ce);

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[IDLE_GO_B] && periph_irq && osc_run |=> !ctl_q[IDLE_GO_B]);

  // R5
  pd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[PD_GO_B] |=> ctl_q[PD_GO_B] && !osc_run && !periph_ce);

  // R6
  pin_pd_chk: assert property (@(posedge clk) disable iff (rst)
    !hwpd_n |=> !osc_run && !cpu_ce);

  // R7
  slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[SLOW_B] && periph_ce && !sfr_we |=> !periph_ce);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_run && !periph_irq |=> $stable(ctl_q));
endmodule

// File: tb/pwr_mode_ctl_tb_top.sv
module pwr_mode_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic       hwpd_n = 1'b1;
  logic       periph_irq = 1'b0;
  logic       cpu_ce, periph_ce, osc_run;
  logic [7:0] ctl_q;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctl dut_i (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
    .hwpd_n(hwpd_n), .periph_irq(periph_irq),
    .cpu_ce(cpu_ce), .periph_ce(periph_ce), .osc_run(osc_run), .ctl_q(ctl_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cyc(1); rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    sfr_we = 1'b1; sfr_wdata = v; cyc(1); sfr_we = 1'b0;
  endtask

  task automatic pulse_irq();
    periph_irq = 1'b1; cyc(1); periph_irq = 1'b0;
  endtask

  initial begin
    int cnt;
    logic [7:0] exp;
    cyc(2); rst = 1'b0;
    // R1
    chk("R1 reg", ctl_q, 0); chk("R1 osc", osc_run, 1);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin cnt += cpu_ce + periph_ce; cyc(1); end
    chk("R1 ce", cnt, 16);

    // R2 R3 R9 idle sweep over every arming value
    for (int v = 0; v < 256; v++) begin
      do_reset(); wr(v[7:0]);
      exp = v[7:0] & 8'h9F;
      chk("R9 store", ctl_q, exp);
      wr(8'h20);
      chk("R2 R3 idle sweep", ctl_q, (v[0] && !v[5]) ? 8'h20 : 8'h00);
    end

    // R5 R3 power-down sweep
    for (int v = 0; v < 256; v++) begin
      do_reset(); wr(v[7:0]); wr(8'h40);
      chk("R5 pd sweep", ctl_q, (v[1] && !v[6]) ? 8'h40 : 8'h00);
    end

    // R2 with the or-style second write
    do_reset(); wr(8'h01); wr(8'h21);
    chk("R2 reg", ctl_q, 8'h21); chk("R2 cpu", cpu_ce, 0); chk("R2 periph", periph_ce, 1);
    // R8 write in idle ignored
    wr(8'h10); chk("R8 idle write", ctl_q, 8'h21);
    // R4 wake
    pulse_irq();
    chk("R4 cpu", cpu_ce, 1); chk("R4 reg", ctl_q, 8'h00);
    pulse_irq(); chk("R4 no idle", ctl_q, 8'h00);

    // R3 intervening write disarms
    do_reset(); wr(8'h01); wr(8'h04); wr(8'h20);
    chk("R3 disarm", ctl_q, 8'h00); chk("R3 cpu", cpu_ce, 1);

    // R5 power-down stays through irq and writes
    do_reset(); wr(8'h02); wr(8'h42);
    chk("R5 osc", osc_run, 0); chk("R5 ce", cpu_ce | periph_ce, 0);
    pulse_irq(); wr(8'h00); cyc(3);
    chk("R5 stay", ctl_q, 8'h42); chk("R5 osc stay", osc_run, 0);
    do_reset(); chk("R5 reset exit", osc_run, 1);

    // R6 pin power-down
    do_reset(); wr(8'h84);
    hwpd_n = 1'b0; cyc(1);
    chk("R6 osc", osc_run, 0); chk("R6 ce", cpu_ce | periph_ce, 0);
    wr(8'h00); chk("R8 pin write", ctl_q, 8'h84);
    hwpd_n = 1'b1; cyc(1);
    chk("R6 back", osc_run, 1); chk("R6 keep", ctl_q, 8'h84);

    // R7 slow-down
    do_reset(); wr(8'h10);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin cnt += periph_ce; cyc(1); end
    chk("R7 slow periph", cnt, 64 / 8);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin cnt += cpu_ce; cyc(1); end
    chk("R7 slow cpu", cnt, 64 / 8);
    wr(8'h00);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin cnt += periph_ce; cyc(1); end
    chk("R7 resume", cnt, 16);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule